// File: doc/BRIEF.md
# Host Interrupt Status and Mask Register

This block is one byte-wide, host-addressable register inside a video decoder. A host read of its address returns eight interrupt status bits. A host write to the same address loads eight per-source mask bits, using the same bit positions. Event strobes and levels come from the decoder core: run/stop commands, a compare match, a picture-boundary strobe, an auxiliary data-ready level and five single-cycle event pulses. The block turns them into status bits and drives one active-low interrupt line to the host.

The sources follow different rules. The run/stop bit mirrors a live state. A read leaves it unchanged, and it requests an interrupt on both of its transitions. The data-ready bit captures only a not-ready-to-ready edge and clears on a read, so it stays quiet while data remains available. The other event bits are sticky until read. The host services an interrupt by reading the register. That read clears every pending request and lets the line go high again.

Top module: `host_irq_status_reg`

## Requirements
- R1: Only an access with `host_addr` equal to 0x000 reaches the register. A read at any other address returns 0x00 and clears nothing, and a write at any other address leaves the masks unchanged.
- R2: After reset all status bits read 0, all mask bits are 1 and `irq_n` is high.
- R3: Bit 0 reads the current run state (1 running, 0 stopped). A stop command (`cmd_valid`=1, `cmd_start`=0) makes it read 0 one cycle later. Every change of bit 0 creates a pending interrupt request for source 0.
- R4: A host read never changes bit 0.
- R5: Stopped-to-running happens only in a cycle with `pic_boundary`=1, and only after a start command (`cmd_valid`=1, `cmd_start`=1) or an armed compare match has been registered in an earlier cycle.
- R6: A compare match (`cmp_match`=1) counts only while `cmp_armed`=1 and the block is stopped. It never stops a running decoder.
- R7: Bit 1 is set one cycle after `aux_ready` goes from 0 to 1, and clears on a read at 0x000. While `aux_ready` stays 1 it is not set again.
- R8: Bits 2 (first slice), 3 (sequence end), 4 (transfer done), 6 (audio sync) and 7 (new field) are set by a one-cycle pulse on their event input and clear on a read at 0x000. An event pulse in the same cycle as the read leaves its bit set.
- R9: A write at 0x000 loads the masks from `host_wdata`, bit for bit. A source whose mask bit is 1 never drives `irq_n` low.
- R10: `irq_n` is low exactly while some unmasked request is pending. A read at 0x000 clears the pending request of source 0.
- R11: Bit 5 always reads 0, whatever was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | ADDR_W | Host register address |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Mask value to load |
| host_rdata | output | 8 | Status value returned during a read |
| cmd_valid | input | 1 | Start/stop command strobe |
| cmd_start | input | 1 | Command kind: 1 start, 0 stop |
| cmp_armed | input | 1 | Start-on-compare enabled (level) |
| cmp_match | input | 1 | Compare match strobe |
| pic_boundary | input | 1 | Picture start-code boundary strobe |
| aux_ready | input | 1 | Auxiliary/user data available (level) |
| evt_slice | input | 1 | First slice start code seen (pulse) |
| evt_seq_end | input | 1 | Sequence end code seen (pulse) |
| evt_xfer_done | input | 1 | Memory transfer finished (pulse) |
| evt_audio_sync | input | 1 | Audio sync recovered (pulse) |
| evt_new_field | input | 1 | New display field (pulse) |
| irq_n | output | 1 | Active-low interrupt to the host |

## Verification
Read data is combinational, so it is valid in the same cycle the read strobe is held. Every status bit, pending request and mask takes one register stage, so its effect appears on `host_rdata` and `irq_n` in the cycle after the clock edge that samples the stimulus. The bench applies all inputs just after a falling edge, lets exactly one rising edge pass, and samples at the following falling edge. A read value is sampled just after the read strobe is raised, before that edge. That spacing lets the collision case check both sides of one edge: the read that races an event returns the old value, and the next read shows the bit still set.

// File: rtl/host_irq_pkg.sv
// Package: bit positions and derived constants shared by the interrupt
// status register and its sub-blocks. Assumes an 8-bit host data path.
package host_irq_pkg;
    localparam int unsigned REG_W      = 8;
    localparam int unsigned POS_RUN    = 0;
    localparam int unsigned POS_AUX    = 1;
    localparam int unsigned POS_SLICE  = 2;
    localparam int unsigned POS_SEQEND = 3;
    localparam int unsigned POS_XFER   = 4;
    localparam int unsigned POS_RSVD   = 5;
    localparam int unsigned POS_AUDIO  = 6;
    localparam int unsigned POS_FIELD  = 7;
    // Positions handled by the sticky clear-on-read bank.
    localparam logic [REG_W-1:0] STICKY_POS =
        (REG_W'(1) << POS_SLICE) | (REG_W'(1) << POS_SEQEND) |
        (REG_W'(1) << POS_XFER)  | (REG_W'(1) << POS_AUDIO)  |
        (REG_W'(1) << POS_FIELD);
    localparam logic [REG_W-1:0] RSVD_POS = REG_W'(1) << POS_RSVD;
endpackage

// File: rtl/run_state_tracker.sv
// Module: run_state_tracker
// Keeps the decoder run/stop state shown in status bit 0, plus a pending
// flag that records every change of that state until a host read.
// Assumes: a stop command takes effect at once. A start (command or armed
// compare match) is first held, then accepted on a later picture-boundary
// strobe. A compare match never stops the decoder.
module run_state_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    input  logic cmd_start,
    input  logic cmp_armed,
    input  logic cmp_match,
    input  logic pic_boundary,
    input  logic rd_ack,
    output logic run_o,
    output logic change_o
);
    logic run_q, run_d;
    logic start_hold_q;
    logic change_q;
    logic stop_cmd, start_req;

    assign stop_cmd  = cmd_valid && !cmd_start;
    assign start_req = (cmd_valid && cmd_start) || (cmp_armed && cmp_match);

    // Next run state: stop wins, start only on a boundary with a held start.
    always_comb begin
        run_d = run_q;
        if (stop_cmd)
            run_d = 1'b0;
        else if (!run_q && start_hold_q && pic_boundary)
            run_d = 1'b1;
    end

    // Run state and held start request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q        <= 1'b0;
            start_hold_q <= 1'b0;
        end else begin
            run_q <= run_d;
            if (stop_cmd || run_d)
                start_hold_q <= 1'b0;
            else if (start_req)
                start_hold_q <= 1'b1;
        end
    end

    // Pending change flag: a new change wins over a read in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            change_q <= 1'b0;
        else if (run_d != run_q)
            change_q <= 1'b1;
        else if (rd_ack)
            change_q <= 1'b0;
    end

    assign run_o    = run_q;
    assign change_o = change_q;

    p_read_keeps_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !cmd_valid && !pic_boundary) |=> $stable(run_q));
    p_start_on_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !pic_boundary) |=> !run_q);
    p_compare_never_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !cmd_valid) |=> run_q);
    p_stop_flags_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && stop_cmd) |=> (!run_q && change_q));
endmodule

// File: rtl/ready_edge_flag.sv
// Module: ready_edge_flag
// Captures a 0-to-1 transition of a data-ready level into a flag that
// clears on a host read. Assumes the level is synchronous to clk. A level
// that stays high does not set the flag again.
module ready_edge_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic ready_lvl,
    input  logic rd_ack,
    output logic flag_o
);
    logic ready_q;
    logic flag_q;
    logic rise;

    assign rise = ready_lvl && !ready_q;

    // Previous level, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ready_q <= 1'b0;
        else
            ready_q <= ready_lvl;
    end

    // Flag: set by a rising edge, cleared by a read; the edge wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (rise)
            flag_q <= 1'b1;
        else if (rd_ack)
            flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    p_read_clears_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !rise) |=> !flag_q);
    p_steady_level_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q && ready_q && ready_lvl) |=> !flag_q);
endmodule

// File: rtl/sticky_event_bank.sv
// Module: sticky_event_bank
// One sticky flag per position selected in USED. Each flag is set by a
// one-cycle pulse and cleared by a host read, with the pulse winning a
// collision. Positions not in USED are tied to 0.
module sticky_event_bank #(
    parameter int unsigned          W    = 8,
    parameter logic [W-1:0]         USED = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         rd_ack,
    output logic [W-1:0] flags_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (USED[i]) begin : g_used
            logic flag_q;
            // Sticky flag for one event source.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    flag_q <= 1'b0;
                else if (evt[i])
                    flag_q <= 1'b1;
                else if (rd_ack)
                    flag_q <= 1'b0;
            end
            assign flags_o[i] = flag_q;

            p_event_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
                evt[i] |=> flags_o[i]);
            p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_ack && !evt[i]) |=> !flags_o[i]);
        end else begin : g_unused
            assign flags_o[i] = 1'b0;
        end
    end
endmodule

// File: rtl/host_irq_status_reg.sv
// Module: host_irq_status_reg (top)
// Host register: a read returns the interrupt status, and a write loads the
// per-source masks. All sources are combined onto an active-low interrupt.
// Assumes single-cycle host strobes, synchronous to clk. Read data is
// combinational during the read cycle, and read side effects apply at the
// closing edge.
module host_irq_status_reg #(
    parameter int unsigned ADDR_W   = 10,
    parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              cmd_valid,
    input  logic              cmd_start,
    input  logic              cmp_armed,
    input  logic              cmp_match,
    input  logic              pic_boundary,
    input  logic              aux_ready,
    input  logic              evt_slice,
    input  logic              evt_seq_end,
    input  logic              evt_xfer_done,
    input  logic              evt_audio_sync,
    input  logic              evt_new_field,
    output logic              irq_n
);
    import host_irq_pkg::*;

    logic             hit, rd_ack, wr_ack;
    logic [REG_W-1:0] mask_q;
    logic [REG_W-1:0] evt_vec;
    logic [REG_W-1:0] sticky_flags;
    logic [REG_W-1:0] status;
    logic [REG_W-1:0] request;
    logic             run_lvl, run_change, aux_flag;

    assign hit    = (host_addr == REG_ADDR);
    assign rd_ack = host_rd && hit;
    assign wr_ack = host_wr && hit;

    // Route the event pulses to their bit positions.
    always_comb begin
        evt_vec             = '0;
        evt_vec[POS_SLICE]  = evt_slice;
        evt_vec[POS_SEQEND] = evt_seq_end;
        evt_vec[POS_XFER]   = evt_xfer_done;
        evt_vec[POS_AUDIO]  = evt_audio_sync;
        evt_vec[POS_FIELD]  = evt_new_field;
    end

    run_state_tracker u_run (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_start    (cmd_start),
        .cmp_armed    (cmp_armed),
        .cmp_match    (cmp_match),
        .pic_boundary (pic_boundary),
        .rd_ack       (rd_ack),
        .run_o        (run_lvl),
        .change_o     (run_change)
    );

    ready_edge_flag u_aux (
        .clk       (clk),
        .rst_n     (rst_n),
        .ready_lvl (aux_ready),
        .rd_ack    (rd_ack),
        .flag_o    (aux_flag)
    );

    sticky_event_bank #(
        .W    (REG_W),
        .USED (STICKY_POS)
    ) u_sticky (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt_vec),
        .rd_ack  (rd_ack),
        .flags_o (sticky_flags)
    );

    // Mask register: reset masks everything; the reserved bit stays masked.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '1;
        else if (wr_ack)
            mask_q <= host_wdata | RSVD_POS;
    end

    // Status view and interrupt request vector.
    always_comb begin
        status          = sticky_flags;
        status[POS_RUN] = run_lvl;
        status[POS_AUX] = aux_flag;
        request          = status;
        request[POS_RUN] = run_change;
    end

    assign host_rdata = rd_ack ? status : '0;
    assign irq_n      = ~|(request & ~mask_q);

    p_all_masked_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_q) |-> irq_n);
    p_miss_keeps_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ack |=> $stable(mask_q));
    p_rsvd_reads_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |-> !host_rdata[POS_RSVD]);
endmodule

// File: tb/sim_host_irq_status_reg.sv
`timescale 1ns/1ps
module sim_host_irq_status_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] host_addr = '0;
    logic       host_rd = 1'b0, host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       cmd_valid = 1'b0, cmd_start = 1'b0;
    logic       cmp_armed = 1'b0, cmp_match = 1'b0, pic_boundary = 1'b0;
    logic       aux_ready = 1'b0;
    logic [7:0] ev = '0;
    logic       irq_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    host_irq_status_reg u0 (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cmd_valid(cmd_valid), .cmd_start(cmd_start), .cmp_armed(cmp_armed),
        .cmp_match(cmp_match), .pic_boundary(pic_boundary), .aux_ready(aux_ready),
        .evt_slice(ev[2]), .evt_seq_end(ev[3]), .evt_xfer_done(ev[4]),
        .evt_audio_sync(ev[6]), .evt_new_field(ev[7]), .irq_n(irq_n)
    );

    // Sticky vectors: {event pulses[7:0], mask[7:0], expected irq_n}
    localparam logic [16:0] VEC [7] = '{
        {8'h04, 8'h00, 1'b0},
        {8'h08, 8'h08, 1'b1},
        {8'h10, 8'hEF, 1'b0},
        {8'h40, 8'hFF, 1'b1},
        {8'h80, 8'h7F, 1'b0},
        {8'hDC, 8'hDC, 1'b1},
        {8'h48, 8'hF7, 1'b0}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic [9:0] a, input logic [7:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        tick();
        host_wr = 1'b0; host_addr = '0;
    endtask

    task automatic rd_reg(input logic [9:0] a, output logic [7:0] d);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(posedge clk);
        @(negedge clk);
        host_rd = 1'b0; host_addr = '0;
    endtask

    task automatic run_in(input logic cv, input logic cs, input logic cm, input logic pb);
        cmd_valid = cv; cmd_start = cs; cmp_match = cm; pic_boundary = pb;
        tick();
        cmd_valid = 1'b0; cmd_start = 1'b0; cmp_match = 1'b0; pic_boundary = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] e);
        ev = e;
        tick();
        ev = '0;
    endtask

    initial begin
        #(5.0 * 5000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R2: reset state
        chk("R2 irq_n after reset", {7'b0, irq_n}, 8'h01);
        rd_reg(10'h000, d);
        chk("R2 status after reset", d, 8'h00);
        pulse(8'h04);
        chk("R2 masks all set", {7'b0, irq_n}, 8'h01);
        rd_reg(10'h000, d);
        chk("R8 masked event still recorded", d, 8'h04);

        // Table: R8 sticky set/clear and R9/R10 mask combining
        for (int i = 0; i < 7; i++) begin
            wr_reg(10'h000, VEC[i][8:1]);
            pulse(VEC[i][16:9]);
            chk("R9 irq_n with mask", {7'b0, irq_n}, {7'b0, VEC[i][0]});
            rd_reg(10'h000, d);
            chk("R8 sticky status", d, VEC[i][16:9]);
            chk("R10 irq_n after read", {7'b0, irq_n}, 8'h01);
        end

        // R1: other addresses
        wr_reg(10'h000, 8'h00);
        pulse(8'h04);
        rd_reg(10'h001, d);
        chk("R1 miss read returns 0", d, 8'h00);
        wr_reg(10'h001, 8'hFF);
        chk("R1 miss write keeps masks", {7'b0, irq_n}, 8'h00);
        rd_reg(10'h000, d);
        chk("R1 miss read did not clear", d, 8'h04);

        // R5/R3: start path
        run_in(1'b0, 1'b0, 1'b0, 1'b1);
        rd_reg(10'h000, d);
        chk("R5 boundary without start", d, 8'h00);
        run_in(1'b1, 1'b1, 1'b0, 1'b0);
        rd_reg(10'h000, d);
        chk("R5 start held until boundary", d, 8'h00);
        chk("R5 no irq before boundary", {7'b0, irq_n}, 8'h01);
        run_in(1'b0, 1'b0, 1'b0, 1'b1);
        chk("R3 start edge raises irq", {7'b0, irq_n}, 8'h00);
        rd_reg(10'h000, d);
        chk("R3 running reads 1", d, 8'h01);
        chk("R10 read clears run pending", {7'b0, irq_n}, 8'h01);
        rd_reg(10'h000, d);
        chk("R4 read keeps bit0", d, 8'h01);
        run_in(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R3 stop edge raises irq", {7'b0, irq_n}, 8'h00);
        rd_reg(10'h000, d);
        chk("R3 stopped reads 0", d, 8'h00);

        // R6: compare match
        run_in(1'b0, 1'b0, 1'b1, 1'b0);
        run_in(1'b0, 1'b0, 1'b0, 1'b1);
        rd_reg(10'h000, d);
        chk("R6 unarmed match ignored", d, 8'h00);
        cmp_armed = 1'b1;
        run_in(1'b0, 1'b0, 1'b1, 1'b0);
        run_in(1'b0, 1'b0, 1'b0, 1'b1);
        rd_reg(10'h000, d);
        chk("R6 armed match starts", d, 8'h01);
        run_in(1'b0, 1'b0, 1'b1, 1'b1);
        chk("R6 match while running no irq", {7'b0, irq_n}, 8'h01);
        rd_reg(10'h000, d);
        chk("R6 match keeps running", d, 8'h01);
        cmp_armed = 1'b0;
        run_in(1'b1, 1'b0, 1'b0, 1'b0);
        rd_reg(10'h000, d);

        // R7: aux ready edge
        aux_ready = 1'b1;
        tick();
        chk("R7 rise raises irq", {7'b0, irq_n}, 8'h00);
        rd_reg(10'h000, d);
        chk("R7 bit1 set", d, 8'h02);
        repeat (3) tick();
        chk("R7 steady level no irq", {7'b0, irq_n}, 8'h01);
        rd_reg(10'h000, d);
        chk("R7 bit1 cleared", d, 8'h00);
        aux_ready = 1'b0;
        tick();
        aux_ready = 1'b1;
        tick();
        rd_reg(10'h000, d);
        chk("R7 new rise sets again", d, 8'h02);
        aux_ready = 1'b0;

        // R8: event colliding with read
        ev = 8'h40;
        rd_reg(10'h000, d);
        ev = '0;
        chk("R8 collision read old value", d, 8'h00);
        rd_reg(10'h000, d);
        chk("R8 event wins collision", d, 8'h40);

        // R11: reserved bit
        wr_reg(10'h000, 8'h00);
        pulse(8'hDC);
        rd_reg(10'h000, d);
        chk("R11 reserved bit reads 0", d & 8'h20, 8'h00);
        chk("R11 other bits intact", d, 8'hDC);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule